// File: doc/BRIEF.md
# Serial Slave Receiver/Transmitter with Ready/Busy Handshake

This block is the slave end of a synchronous serial link. An external master drives the serial clock. On every frame the block shifts an 8-bit word in from the data input and shifts a word out on the data output, most significant bit first. The serial clock and data input are brought into the system clock domain through a two-flop synchronizer, and the clock edges are detected there. A received frame goes into a holding register, which the host drains through a valid/ready stream port.

When the holding register is still full and another frame completes, the new word stays parked in the shift register. With the handshake enabled, the block then pulls its ready line low. The master must stop toggling the serial clock until the line returns high. The host reads the holding register with a valid/ready handshake, and the parked word moves across on the next clock. The ready line rises in that same cycle, and the valid flag stays high throughout.

Host stream rules: `rx_valid` and `rx_data` hold steady until a cycle in which `rx_ready` is also high. That cycle consumes the word. `rx_ready` may be held high without harm. A phase select input decides which serial clock edge samples and which edge shifts. The serial clock idles low.

Top module: `hs_serial_slave`

## Requirements
- R1: After reset, `rx_valid` is 0, `rdy_out` is 1 and `frame_done` is 0.
- R2: Eight sampling edges assemble one received word, MSB first. The sampling edge is the serial clock rising edge when `phase_sel`=0 and the falling edge when `phase_sel`=1. Serial levels must stay in place for at least 3 system clocks.
- R3: The transmit word is taken from `tx_data` and sent MSB first. With `phase_sel`=0, bit 7 is on `sdo_out` before the first rising edge and each falling edge moves on to the next bit. With `phase_sel`=1, each rising edge presents the next bit, starting with bit 7.
- R4: A completed word sets `rx_valid` with the word on `rx_data`. Both stay unchanged until `rx_valid && rx_ready`. That handshake clears `rx_valid` if no further word is waiting.
- R5: When `hs_en`=1 and a frame completes while `rx_valid` is 1, `rdy_out` goes low and stays low until the host reads. The holding register keeps the older word during that time.
- R6: A read while a word is parked moves that word into the holding register on the next clock. In that cycle `rdy_out` returns high and `rx_valid` stays 1.
- R7: When `hs_en`=0, `rdy_out` stays 1 whatever the holding register state.
- R8: `frame_done` pulses high for exactly one system clock each time a word enters the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_en | input | 1 | Ready/busy handshake enable |
| phase_sel | input | 1 | 0: sample on rising edge; 1: sample on falling edge |
| sclk_in | input | 1 | Serial clock from the master (asynchronous) |
| sdi_in | input | 1 | Serial data from the master |
| sdo_out | output | 1 | Serial data to the master |
| rdy_out | output | 1 | High = ready, low = busy (master stalls clock) |
| tx_data | input | 8 | Word to transmit in the next frame |
| rx_valid | output | 1 | Holding register full |
| rx_ready | input | 1 | Host accepts the holding word |
| rx_data | output | 8 | Holding register contents |
| frame_done | output | 1 | One-cycle strobe per word moved into the holding register |

## Verification
If the bit counter drifts, the fault shows up on `rx_data` at the next read as a rotated or shifted word. It also shows up on `sdo_out` as a bit out of place within the same frame. A pending flag left set or cleared in error shows at the ports within a few system clocks after a frame ends. The signs are a `rdy_out` that stays low after a read, a busy line that never appears on a back-to-back frame, or a `frame_done` count that does not match the number of words read. A holding register that is overwritten early shows as the older word missing at the read that follows a busy period.

// File: rtl/hs_slave_pkg.sv
package hs_slave_pkg;
  typedef enum logic {
    PH_SAMPLE_RISE = 1'b0,
    PH_SAMPLE_FALL = 1'b1
  } phase_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hs_shifter.sv
module hs_shifter
  import hs_slave_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  phase_e             phase,
  input  logic               sclk_s,
  input  logic               sdi_s,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               sdo,
  output logic               frame_end,
  output logic [FRAME_W-1:0] rx_word
);
  localparam int CW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic               sclk_d;
  logic               rise, fall, smp_edge, shf_edge;
  logic [CW-1:0]      cnt;
  logic [FRAME_W-1:0] rx_sh, tx_sh;
  logic               sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign smp_edge = (phase == PH_SAMPLE_FALL) ? fall : rise;
  assign shf_edge = (phase == PH_SAMPLE_FALL) ? rise : fall;

  // receive side: counter and shift register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      rx_sh     <= '0;
      frame_end <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      if (smp_edge) begin
        rx_sh <= {rx_sh[FRAME_W-2:0], sdi_s};
        if (cnt == LAST) begin
          cnt       <= '0;
          frame_end <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign rx_word = rx_sh;

  // transmit side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      sdo_q <= 1'b0;
    end else if (phase == PH_SAMPLE_RISE) begin
      if (cnt == '0)     tx_sh <= tx_word;
      else if (shf_edge) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
    end else if (shf_edge) begin
      if (cnt == '0) begin
        sdo_q <= tx_word[FRAME_W-1];
        tx_sh <= {tx_word[FRAME_W-2:0], 1'b0};
      end else begin
        sdo_q <= tx_sh[FRAME_W-1];
        tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
      end
    end
  end

  assign sdo = (phase == PH_SAMPLE_FALL) ? sdo_q : tx_sh[FRAME_W-1];

  // R2: a completed frame always leaves the counter at bit zero
  p_count_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (cnt == '0));

  // R3: mid-frame, the output bit moves only on a shifting edge
  p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shf_edge && cnt != '0 && $stable(phase)) |=> $stable(sdo));
endmodule

// File: rtl/hs_holding.sv
module hs_holding #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hs_en,
  input  logic               frame_end,
  input  logic [FRAME_W-1:0] rx_word,
  input  logic               rd_ready,
  output logic               rd_valid,
  output logic [FRAME_W-1:0] rd_data,
  output logic               rdy,
  output logic               done
);
  logic               pend_q, full_q, take, xfer;
  logic [FRAME_W-1:0] hold_q;

  assign take = full_q & rd_ready;
  assign xfer = pend_q & (~full_q | take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      full_q <= 1'b0;
      hold_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= xfer;
      if (frame_end)  pend_q <= 1'b1;
      else if (xfer)  pend_q <= 1'b0;
      if (xfer) begin
        hold_q <= rx_word;
        full_q <= 1'b1;
      end else if (take) begin
        full_q <= 1'b0;
      end
    end
  end

  assign rd_valid = full_q;
  assign rd_data  = hold_q;
  assign rdy      = ~(hs_en & pend_q & full_q);

  // R4: an offered word waits unchanged for the host
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R5: busy is only ever raised against a full holding register
  p_busy_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> rd_valid);

  // R6: a read during busy releases the line and keeps the flag set
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && rd_ready) |=> (rdy && rd_valid));

  // R7: handshake off means the line never drops
  p_off_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_en |-> rdy);

  // R8: the strobe never lasts two cycles
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/hs_serial_slave.sv
module hs_serial_slave
  import hs_slave_pkg::*;
#(
  parameter int FRAME_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hs_en,
  input  logic               phase_sel,
  input  logic               sclk_in,
  input  logic               sdi_in,
  output logic               sdo_out,
  output logic               rdy_out,
  input  logic [FRAME_W-1:0] tx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [FRAME_W-1:0] rx_data,
  output logic               frame_done
);
  logic [1:0]         sync_q;
  logic               frame_end;
  logic [FRAME_W-1:0] rx_word;
  phase_e             phase;

  assign phase = phase_e'(phase_sel);

  hs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk_in, sdi_in}),
    .q     (sync_q)
  );

  hs_shifter #(.FRAME_W(FRAME_W)) i_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .sclk_s    (sync_q[1]),
    .sdi_s     (sync_q[0]),
    .tx_word   (tx_data),
    .sdo       (sdo_out),
    .frame_end (frame_end),
    .rx_word   (rx_word)
  );

  hs_holding #(.FRAME_W(FRAME_W)) i_holding (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_en     (hs_en),
    .frame_end (frame_end),
    .rx_word   (rx_word),
    .rd_ready  (rx_ready),
    .rd_valid  (rx_valid),
    .rd_data   (rx_data),
    .rdy       (rdy_out),
    .done      (frame_done)
  );
endmodule

// File: tb/test_hs_serial_slave.sv
module test_hs_serial_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {phase_sel, word from master, word from slave}
  localparam logic [16:0] VEC [0:NVEC-1] = '{
    {1'b0, 8'hA5, 8'h3C},
    {1'b0, 8'h01, 8'h80},
    {1'b1, 8'hC3, 8'h5A},
    {1'b1, 8'hFF, 8'h00},
    {1'b0, 8'h00, 8'hFF},
    {1'b1, 8'h96, 8'h69}
  };

  logic clk = 0, rst_n = 0, hs_en = 1, phase_sel = 0;
  logic sclk_in = 0, sdi_in = 0, rx_ready = 0;
  logic [7:0] tx_data = 8'h00;
  logic sdo_out, rdy_out, rx_valid, frame_done;
  logic [7:0] rx_data;

  int checks = 0, errors = 0;
  int done_cnt = 0, done_long = 0, low_off = 0;
  logic done_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_serial_slave i_hs_serial_slave (
    .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .phase_sel(phase_sel),
    .sclk_in(sclk_in), .sdi_in(sdi_in), .sdo_out(sdo_out), .rdy_out(rdy_out),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .frame_done(frame_done)
  );

  always @(negedge clk) begin
    if (frame_done) done_cnt++;
    if (frame_done && done_prev) done_long++;
    done_prev <= frame_done;
    if (!hs_en && !rdy_out) low_off++;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] m, output logic [7:0] s);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) sdi_in = m[i];
      repeat (4) @(negedge clk);
      if (!phase_sel) s[i] = sdo_out;
      sclk_in = 1;
      repeat (8) @(negedge clk);
      if (phase_sel) s[i] = sdo_out;
      sclk_in = 0;
      repeat (4) @(negedge clk);
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic read_word(output logic [7:0] d);
    @(negedge clk);
    while (!rx_valid) @(negedge clk);
    d = rx_data;
    rx_ready = 1;
    @(negedge clk);
    rx_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    repeat (3) @(negedge clk);
    check("R1 rx_valid", {7'd0, rx_valid}, 8'd0);
    check("R1 rdy_out", {7'd0, rdy_out}, 8'd1);
    check("R1 frame_done", {7'd0, frame_done}, 8'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 rx_valid after release", {7'd0, rx_valid}, 8'd0);

    // vector loop: both phases, read after every frame
    for (int v = 0; v < NVEC; v++) begin
      phase_sel = VEC[v][16];
      tx_data   = VEC[v][7:0];
      repeat (4) @(negedge clk);
      send_frame(VEC[v][15:8], s);
      check("R3 slave output word", s, VEC[v][7:0]);
      check("R8 strobe count", 8'(done_cnt), 8'(v + 1));
      read_word(d);
      check("R2 received word", d, VEC[v][15:8]);
      check("R4 cleared after read", {7'd0, rx_valid}, 8'd0);
    end

    // R4 / R5 / R6: back-to-back frames with handshake on
    phase_sel = 0; tx_data = 8'h11;
    send_frame(8'h5C, s);
    repeat (30) @(negedge clk);
    check("R4 valid held", {7'd0, rx_valid}, 8'd1);
    check("R4 data held", rx_data, 8'h5C);
    check("R5 ready before second", {7'd0, rdy_out}, 8'd1);
    send_frame(8'hE7, s);
    check("R5 busy on full", {7'd0, rdy_out}, 8'd0);
    check("R5 old word kept", rx_data, 8'h5C);
    check("R8 strobe count before read", 8'(done_cnt), 8'(NVEC + 1));
    read_word(d);
    check("R5 read old word", d, 8'h5C);
    check("R6 ready released", {7'd0, rdy_out}, 8'd1);
    check("R6 valid stays", {7'd0, rx_valid}, 8'd1);
    check("R6 parked word moved", rx_data, 8'hE7);
    read_word(d);
    check("R6 second word", d, 8'hE7);
    check("R4 empty again", {7'd0, rx_valid}, 8'd0);

    // R7: handshake off, no stall line
    hs_en = 0; phase_sel = 1;
    send_frame(8'h2B, s);
    send_frame(8'hD4, s);
    check("R7 ready high", {7'd0, rdy_out}, 8'd1);
    check("R7 low cycles", 8'(low_off), 8'd0);
    check("R7 first word kept", rx_data, 8'h2B);
    read_word(d);
    check("R7 parked word moved", rx_data, 8'hD4);
    read_word(d);
    check("R7 second word", d, 8'hD4);
    hs_en = 1;

    repeat (5) @(negedge clk);
    check("R8 total strobes", 8'(done_cnt), 8'(NVEC + 4));
    check("R8 no long strobe", 8'(done_long), 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule